// File: doc/BRIEF.md
# Memory Self-Test Sequencer with Protected Command Register

This block owns the built-in memory check of four DSP engines. Software sends one command word over a register write port. The word carries three fields: a soft reset strobe, a check start strobe and a two-bit selection. A write-protect input can lock out every write. A start is accepted only when the sequencer is idle and all DSP enable inputs are low. The sequencer then walks the memories of the selected engines. For each engine it first reads the 16-word ROM and checks the 8-bit running sum against a fixed golden value. It then writes a pattern into the 16-word SRAM and reads it back to compare.

Each engine's ROM and SRAM are modelled inside the block. Two per-engine defect inputs emulate faults. A ROM defect flips bit 0 of ROM word 5. An SRAM defect makes bit 0 of every word written to that engine's SRAM stick at 0. The block reports through two error flags, a busy output and a sticky check-done status that a status read clears.

The sequencer has seven states:
- ST_IDLE goes to ST_ROM_RD on an accepted start.
- ST_ROM_RD issues the 16 ROM reads, then goes to ST_ROM_END, where the last word is summed and compared.
- ST_SRAM_WR writes the 16 pattern words.
- ST_SRAM_RD reads them back, then goes to ST_SRAM_END, where the last word is compared.
- ST_SRAM_END returns to ST_ROM_RD for the next engine, but only when all engines are selected and DSP3 is not yet done. Otherwise it goes to ST_FINISH.
- ST_FINISH sets check-done and goes back to ST_IDLE.

A soft reset sends any state to ST_IDLE.

Top module: `memchk_ctrl`

## Requirements
- R1: While `wp_enable` is 1, a write has no effect: no check starts, no soft reset happens, and the flags keep their values.
- R2: Command bit 0 is the soft reset strobe, bit 1 is the check start strobe, and bits 3:2 are the selection. A write of 0 to both strobes changes nothing.
- R3: Each selection code checks a fixed set of engines. Code 0 checks DSP0, DSP1, DSP2 and DSP3, in that order. Code 1 checks only DSP0, code 2 only DSP1 and code 3 only DSP3.
- R4: Defects in engines outside the selection never set `rom_err` or `sram_err`.
- R5: A start is ignored, and produces no check-done event, when any `dsp_enable` bit is 1 or when a check is already running.
- R6: The clock edge that accepts a start clears `rom_err` and `sram_err` and sets `busy`.
- R7: `rom_err` is set when the 8-bit sum of a selected ROM differs from its golden sum. `sram_err` is set when a read-back SRAM word differs from its address XOR 0xA5.
- R8: `check_done` rises, and `busy` falls, 51 edges after the accepting edge for a single engine and 201 edges after it for all engines. The flags are final from that edge on.
- R9: A pulse on `stat_rd` clears `check_done`. If the clear and the end-of-check set fall on the same edge, the set wins.
- R10: A soft reset returns the flags, `check_done` and the sequencer to their reset values. It wins over a start carried in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 4 | Command word: {sel[1:0], start, soft_reset} |
| wp_enable | input | 1 | Write protection; 1 discards writes |
| dsp_enable | input | 4 | Enable bit of each DSP engine |
| stat_rd | input | 1 | Status read; clears check_done |
| fault_rom | input | 4 | Per-engine ROM defect injection |
| fault_sram | input | 4 | Per-engine SRAM stuck-bit injection |
| busy | output | 1 | Check in progress |
| check_done | output | 1 | Sticky end-of-check event |
| rom_err | output | 1 | ROM checksum mismatch seen |
| sram_err | output | 1 | SRAM read-back mismatch seen |

## Verification
Two functions can fall on the same edge: the end-of-check set of `check_done` in ST_FINISH, and a status-read clear. The bench first measures when the set edge comes for a single-engine check. It then starts a new check and raises `stat_rd` so that it is sampled on exactly the edge that sets `check_done`. The status must still read 1 after that edge, and must read 0 only after a later, separate read.

// File: rtl/memchk_pkg.sv
package memchk_pkg;

    localparam int N_DSP     = 4;
    localparam int WORDS     = 16;
    localparam int DW        = 8;
    localparam int AW        = $clog2(WORDS);
    localparam int DSP_W     = $clog2(N_DSP);
    localparam int FAULT_ADR = 5;
    localparam logic [DW-1:0] SRAM_KEY = DW'(8'hA5);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROM_RD,
        ST_ROM_END,
        ST_SRAM_WR,
        ST_SRAM_RD,
        ST_SRAM_END,
        ST_FINISH
    } seq_state_e;

    // Fixed ROM image, computed from engine index and address
    function automatic logic [DW-1:0] rom_word(logic [DSP_W-1:0] d, logic [AW-1:0] a);
        logic [31:0] t;
        t = 32'({d, a}) * 32'd29 + 32'd60;
        return t[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] rom_golden(logic [DSP_W-1:0] d);
        logic [DW-1:0] s;
        s = '0;
        for (int i = 0; i < WORDS; i++) s = s + rom_word(d, AW'(i));
        return s;
    endfunction

    function automatic logic [DW-1:0] sram_pattern(logic [AW-1:0] a);
        return DW'(a) ^ SRAM_KEY;
    endfunction

    // Selection code to first engine: 0->DSP0, 1->DSP0, 2->DSP1, 3->DSP3
    function automatic logic [DSP_W-1:0] first_dsp(logic [1:0] sel);
        case (sel)
            2'd2:    return DSP_W'(1);
            2'd3:    return DSP_W'(3);
            default: return DSP_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/memchk_regif.sv
module memchk_regif
    import memchk_pkg::*;
(
    input  logic             wr_en,
    input  logic [3:0]       wr_data,
    input  logic             wp_enable,
    input  logic [N_DSP-1:0] dsp_enable,
    input  logic             busy,
    output logic             soft_rst,
    output logic             start_go,
    output logic [1:0]       start_sel
);

    logic wr_ok;

    always_comb begin
        wr_ok     = wr_en && !wp_enable;
        soft_rst  = wr_ok && wr_data[0];
        // soft reset wins over a start carried in the same word
        start_go  = wr_ok && wr_data[1] && !wr_data[0] && (dsp_enable == '0) && !busy;
        start_sel = wr_data[3:2];
    end

endmodule

// File: rtl/memchk_banks.sv
module memchk_banks
    import memchk_pkg::*;
(
    input  logic             clk,
    input  logic             rd_en,
    input  logic             rd_sram,
    input  logic [DSP_W-1:0] dsp,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [N_DSP-1:0] fault_rom,
    input  logic [N_DSP-1:0] fault_sram,
    output logic [DW-1:0]    rd_data
);

    localparam int DEPTH = N_DSP * WORDS;

    logic [DW-1:0]       sram [DEPTH];
    logic [DW-1:0]       rom_out;
    logic [DSP_W+AW-1:0] idx;

    always_comb begin
        idx     = {dsp, addr};
        rom_out = rom_word(dsp, addr);
        if (fault_rom[dsp] && addr == AW'(FAULT_ADR))
            rom_out = rom_out ^ DW'(1);
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            sram[idx] <= fault_sram[dsp] ? (wr_data & ~DW'(1)) : wr_data;
        if (rd_en)
            rd_data <= rd_sram ? sram[idx] : rom_out;
    end

endmodule

// File: rtl/memchk_seq.sv
module memchk_seq
    import memchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             start_go,
    input  logic [1:0]       start_sel,
    input  logic             stat_rd,
    input  logic [DW-1:0]    rd_data,
    output logic             mem_rd_en,
    output logic             mem_rd_sram,
    output logic             mem_wr_en,
    output logic [DW-1:0]    mem_wr_data,
    output logic [DSP_W-1:0] mem_dsp,
    output logic [AW-1:0]    mem_addr,
    output logic             busy,
    output logic             rom_err,
    output logic             sram_err,
    output logic             check_done
);

    localparam logic [AW-1:0]    LAST_ADR = AW'(WORDS - 1);
    localparam logic [DSP_W-1:0] LAST_DSP = DSP_W'(N_DSP - 1);

    seq_state_e       state, state_nx;
    logic [AW-1:0]    addr_q, pend_q;
    logic [DSP_W-1:0] dsp_q;
    logic [1:0]       sel_q;
    logic [DW-1:0]    sum_q;
    logic [DW-1:0]    sum_fin;
    logic             rd_valid_q;
    logic             more_dsp;

    assign more_dsp = (sel_q == 2'd0) && (dsp_q != LAST_DSP);
    assign sum_fin  = sum_q + rd_data;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_go) state_nx = ST_ROM_RD;
            ST_ROM_RD:   if (addr_q == LAST_ADR) state_nx = ST_ROM_END;
            ST_ROM_END:  state_nx = ST_SRAM_WR;
            ST_SRAM_WR:  if (addr_q == LAST_ADR) state_nx = ST_SRAM_RD;
            ST_SRAM_RD:  if (addr_q == LAST_ADR) state_nx = ST_SRAM_END;
            ST_SRAM_END: state_nx = more_dsp ? ST_ROM_RD : ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (soft_rst) state <= ST_IDLE;
        else               state <= state_nx;
    end

    always_comb begin
        mem_rd_en   = (state == ST_ROM_RD) || (state == ST_SRAM_RD);
        mem_rd_sram = (state == ST_SRAM_RD);
        mem_wr_en   = (state == ST_SRAM_WR);
        mem_wr_data = sram_pattern(addr_q);
        mem_dsp     = dsp_q;
        mem_addr    = addr_q;
        busy        = (state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0; pend_q <= '0; dsp_q <= '0; sel_q <= '0; sum_q <= '0;
            rd_valid_q <= 1'b0; rom_err <= 1'b0; sram_err <= 1'b0; check_done <= 1'b0;
        end else if (soft_rst) begin
            addr_q <= '0; pend_q <= '0; dsp_q <= '0; sel_q <= '0; sum_q <= '0;
            rd_valid_q <= 1'b0; rom_err <= 1'b0; sram_err <= 1'b0; check_done <= 1'b0;
        end else begin
            rd_valid_q <= mem_rd_en;
            pend_q     <= addr_q;
            unique case (state)
                ST_IDLE: if (start_go) begin
                    rom_err  <= 1'b0;
                    sram_err <= 1'b0;
                    sel_q    <= start_sel;
                    dsp_q    <= first_dsp(start_sel);
                    addr_q   <= '0;
                    sum_q    <= '0;
                end
                ST_ROM_RD: begin
                    addr_q <= addr_q + AW'(1);
                    if (rd_valid_q) sum_q <= sum_fin;
                end
                ST_ROM_END: begin
                    addr_q <= '0;
                    if (sum_fin != rom_golden(dsp_q)) rom_err <= 1'b1;
                end
                ST_SRAM_WR: addr_q <= addr_q + AW'(1);
                ST_SRAM_RD: begin
                    addr_q <= addr_q + AW'(1);
                    if (rd_valid_q && rd_data != sram_pattern(pend_q)) sram_err <= 1'b1;
                end
                ST_SRAM_END: begin
                    if (rd_data != sram_pattern(pend_q)) sram_err <= 1'b1;
                    if (more_dsp) begin
                        dsp_q <= dsp_q + DSP_W'(1);
                        sum_q <= '0;
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
            // end-of-check set wins over a status read on the same edge
            if (state == ST_FINISH) check_done <= 1'b1;
            else if (stat_rd)       check_done <= 1'b0;
        end
    end

endmodule

// File: rtl/memchk_ctrl.sv
module memchk_ctrl
    import memchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_data,
    input  logic             wp_enable,
    input  logic [N_DSP-1:0] dsp_enable,
    input  logic             stat_rd,
    input  logic [N_DSP-1:0] fault_rom,
    input  logic [N_DSP-1:0] fault_sram,
    output logic             busy,
    output logic             check_done,
    output logic             rom_err,
    output logic             sram_err
);

    logic             w_soft_rst, w_start_go;
    logic [1:0]       w_start_sel;
    logic             w_rd_en, w_rd_sram, w_wr_en;
    logic [DW-1:0]    w_wr_data, w_rd_data;
    logic [DSP_W-1:0] w_dsp;
    logic [AW-1:0]    w_addr;

    memchk_regif u_regif (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wp_enable  (wp_enable),
        .dsp_enable (dsp_enable),
        .busy       (busy),
        .soft_rst   (w_soft_rst),
        .start_go   (w_start_go),
        .start_sel  (w_start_sel)
    );

    memchk_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (w_soft_rst),
        .start_go    (w_start_go),
        .start_sel   (w_start_sel),
        .stat_rd     (stat_rd),
        .rd_data     (w_rd_data),
        .mem_rd_en   (w_rd_en),
        .mem_rd_sram (w_rd_sram),
        .mem_wr_en   (w_wr_en),
        .mem_wr_data (w_wr_data),
        .mem_dsp     (w_dsp),
        .mem_addr    (w_addr),
        .busy        (busy),
        .rom_err     (rom_err),
        .sram_err    (sram_err),
        .check_done  (check_done)
    );

    memchk_banks u_banks (
        .clk        (clk),
        .rd_en      (w_rd_en),
        .rd_sram    (w_rd_sram),
        .dsp        (w_dsp),
        .addr       (w_addr),
        .wr_en      (w_wr_en),
        .wr_data    (w_wr_data),
        .fault_rom  (fault_rom),
        .fault_sram (fault_sram),
        .rd_data    (w_rd_data)
    );

endmodule

// File: rtl/memchk_ctrl_chk.sv
module memchk_ctrl_chk
    import memchk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_data,
    input logic             wp_enable,
    input logic [N_DSP-1:0] dsp_enable,
    input logic             stat_rd,
    input logic             start_go,
    input logic             busy,
    input logic             check_done,
    input logic             rom_err,
    input logic             sram_err
);

    assert_wp_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_enable && !busy) |=> !busy);

    assert_wp_keeps_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_enable && !busy) |=> ($stable(rom_err) && $stable(sram_err)));

    assert_enabled_blocks_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dsp_enable != '0) && !busy) |=> !busy);

    assert_start_clears_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> (busy && !rom_err && !sram_err));

    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(check_done) |-> ($past(busy) && !busy));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && check_done && !busy) |=> !check_done);

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wp_enable && wr_data[0]) |=> (!busy && !check_done && !rom_err && !sram_err));

endmodule

bind memchk_ctrl memchk_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wp_enable  (wp_enable),
    .dsp_enable (dsp_enable),
    .stat_rd    (stat_rd),
    .start_go   (w_start_go),
    .busy       (busy),
    .check_done (check_done),
    .rom_err    (rom_err),
    .sram_err   (sram_err)
);

// File: tb/test_memchk_ctrl.sv
`timescale 1ns/1ps
module test_memchk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic       wp_enable = 1'b0;
    logic [3:0] dsp_enable = '0;
    logic       stat_rd = 1'b0;
    logic [3:0] fault_rom = '0;
    logic [3:0] fault_sram = '0;
    logic       busy, check_done, rom_err, sram_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int t_wr = 0;
    int lat = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    memchk_ctrl i_memchk_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wp_enable(wp_enable), .dsp_enable(dsp_enable), .stat_rd(stat_rd),
        .fault_rom(fault_rom), .fault_sram(fault_sram),
        .busy(busy), .check_done(check_done), .rom_err(rom_err), .sram_err(sram_err)
    );

    // {sel[1:0], fault_rom[3:0], fault_sram[3:0], exp_rom, exp_sram}
    localparam logic [11:0] VEC [8] = '{
        {2'd0, 4'b0000, 4'b0000, 1'b0, 1'b0},
        {2'd0, 4'b0000, 4'b0100, 1'b0, 1'b1},
        {2'd1, 4'b1000, 4'b0010, 1'b0, 1'b0},
        {2'd1, 4'b0001, 4'b0000, 1'b1, 1'b0},
        {2'd2, 4'b0010, 4'b0010, 1'b1, 1'b1},
        {2'd3, 4'b0100, 4'b0100, 1'b0, 1'b0},
        {2'd3, 4'b0000, 4'b1000, 1'b0, 1'b1},
        {2'd0, 4'b0100, 4'b0000, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        t_wr = cyc;
    endtask

    task automatic wait_done();
        while (!check_done && cyc < t_wr + 1000) @(negedge clk);
        lat = cyc - t_wr;
    endtask

    task automatic rd_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset busy", busy, 0);
        chk("reset done", check_done, 0);
        chk("reset rom_err", rom_err, 0);
        chk("reset sram_err", sram_err, 0);

        // R2: zero strobes change nothing
        wr(4'b1100);
        chk("R2 no-op write busy", busy, 0);

        // table walk: R3 R4 R7 R8 R9
        for (int i = 0; i < 8; i++) begin
            fault_rom  = VEC[i][9:6];
            fault_sram = VEC[i][5:2];
            wr({VEC[i][11:10], 2'b10});
            chk("R6 busy after start", busy, 1);
            wait_done();
            chk("R8 R3 latency", lat, (VEC[i][11:10] == 2'd0) ? 201 : 51);
            chk("R7 R4 rom_err", rom_err, VEC[i][1]);
            chk("R7 R4 sram_err", sram_err, VEC[i][0]);
            chk("R8 busy low at done", busy, 0);
            rd_status();
            chk("R9 read clears done", check_done, 0);
        end
        fault_rom = '0; fault_sram = '0;

        // R1: rom_err is 1 from last vector; protected writes discarded
        wp_enable = 1'b1;
        wr(4'b0001);
        chk("R1 protected soft reset", rom_err, 1);
        wr(4'b0010);
        chk("R1 protected start busy", busy, 0);
        chk("R1 protected start flag", rom_err, 1);
        wp_enable = 1'b0;

        // R6: accepted start clears flags on its edge
        wr(4'b0110);
        chk("R6 rom_err cleared", rom_err, 0);
        wait_done();
        rd_status();

        // R5: engine enabled blocks the start, no event
        dsp_enable = 4'b0100;
        wr(4'b0010);
        chk("R5 enabled busy", busy, 0);
        repeat (300) @(negedge clk);
        chk("R5 enabled no event", check_done, 0);
        dsp_enable = '0;

        // R5: start while running is ignored
        fault_rom = 4'b0001;
        wr(4'b0110);
        repeat (10) @(negedge clk);
        t_wr = t_wr;
        begin
            int t0;
            t0 = t_wr;
            wr(4'b0010);
            t_wr = t0;
        end
        wait_done();
        chk("R5 running start ignored latency", lat, 51);
        chk("R5 running start flags", rom_err, 1);
        rd_status();
        repeat (300) @(negedge clk);
        chk("R5 no second event", check_done, 0);
        fault_rom = '0;

        // R9: status read on the same edge as the end-of-check set
        wr(4'b1010);
        while (cyc < t_wr + 50) @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R9 set wins over read", check_done, 1);
        rd_status();
        chk("R9 later read clears", check_done, 0);

        // R10: soft reset wins over start in the same word
        fault_sram = 4'b0001;
        wr(4'b0110);
        wait_done();
        chk("R10 setup sram_err", sram_err, 1);
        wr(4'b0011);
        chk("R10 busy", busy, 0);
        chk("R10 done", check_done, 0);
        chk("R10 sram_err", sram_err, 0);
        // R10: soft reset during a check
        wr(4'b0010);
        repeat (20) @(negedge clk);
        wr(4'b0001);
        chk("R10 mid-check busy", busy, 0);
        repeat (300) @(negedge clk);
        chk("R10 mid-check no event", check_done, 0);
        fault_sram = '0;

        finish_run();
    end

endmodule